// File: doc/BRIEF.md
# Module Space Address Decoder with Byte-Order Control

This block sits between a host bus and four plug-in module slots. A host access arrives tagged with one of three local windows. In the register-style window the address is split into a slot number, a sub-space (I/O, identification or interrupt) and an offset. In the halfword memory window the address is split into a slot number and a 23-bit offset. In the byte memory window it is split into a slot number and a 22-bit offset. The decoder drives a one-hot slot select, a space code, the offset, read and write strobes and the write data toward the modules.

Each of the first two windows has its own big-endian flag. When a flag is set, a byte access has address bit 0 inverted before decoding, and a halfword access has its two data bytes exchanged in both directions. The flags are held in a small byte-addressed configuration file, next to a third flag that is passed out for a separate register window. Reads from the interrupt space at offsets 0 and 2 raise a per-slot, per-line acknowledge pulse. Accesses to empty or out-of-range slots select nothing and read back zero. Read data from the modules is adjusted and registered, and it is returned with a valid strobe one cycle after the request.

Top module: `modspace_decoder`

## Requirements
- R1: After a synchronous active-low reset all three byte-order flags are clear, `rd_valid` is low and `regwin_be` is low.
- R2: For window code 0, the slot is the address shifted right by 8 and the sub-space is address bits 7:6. Sub-space 2 selects ID space (`mod_space`=1) with offset bits 5:0. Sub-space 3 selects INT space (`mod_space`=2) with offset bits 5:0. Sub-spaces 0 and 1 select I/O space (`mod_space`=0) with offset bits 6:0.
- R3: For window code 1, the slot is the address shifted right by 23, the offset is address bits 22:0 and `mod_space` is 3. Byte and halfword accesses are both accepted.
- R4: For window code 2, the slot is the address shifted right by 22, the offset is address bits 21:0 and `mod_space` is 4. The byte-order flags never affect this window. A halfword access in this window selects no slot, gives no strobe and reads zero.
- R5: While the flag of window 0 or 1 is set, a byte access in that window is decoded with address bit 0 inverted.
- R6: While the flag of window 0 or 1 is set, a halfword access in that window has its write data bytes exchanged on `mod_wdata` and its read data bytes exchanged on `rd_data`. With the flag clear, data passes unchanged.
- R7: A configuration write to byte 0x2B, 0x2F or 0x33 loads bit 0 of the data into the flag of the register window, window 0 or window 1 respectively. A configuration read of those bytes returns the stored constant (0xD4, 0x14, 0x14) ORed with the flag. Every other byte reads zero. The register-window flag drives `regwin_be`.
- R8: A read that hits INT space at offset 0 pulses `int_ack` bit slot*2, and at offset 2 it pulses bit slot*2+1. Writes and other offsets pulse nothing.
- R9: An access to a slot whose `slot_present` bit is low selects nothing, raises neither strobe nor any acknowledge, and returns zero read data.
- R10: A computed slot number of 4 or more is treated as an absent slot.
- R11: `rd_valid` is high for exactly the cycle after each read request, with `rd_data` valid in that cycle. A byte read returns the low module byte, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Host access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_win | input | 2 | Window code: 0 register-style, 1 halfword memory, 2 byte memory, 3 unused |
| acc_half | input | 1 | 1 = halfword access, 0 = byte access |
| acc_addr | input | 25 | Host byte address within the window |
| acc_wdata | input | 16 | Host write data |
| slot_present | input | 4 | One bit per installed module |
| mod_sel | output | 4 | One-hot slot select, zero when nothing is hit |
| mod_space | output | 3 | Space code: 0 I/O, 1 ID, 2 INT, 3 halfword memory, 4 byte memory |
| mod_offset | output | 23 | Offset inside the selected space |
| mod_wr | output | 1 | Write strobe to the selected slot |
| mod_rd | output | 1 | Read strobe to the selected slot |
| mod_wdata | output | 16 | Write data after byte-order adjustment |
| mod_rdata | input | 16 | Raw read data from the selected slot, same cycle |
| int_ack | output | 8 | Interrupt acknowledge pulses, bit slot*2+line |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 16 | Adjusted read data |
| cfg_wr | input | 1 | Configuration byte write |
| cfg_addr | input | 7 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data, combinational |
| regwin_be | output | 1 | Byte-order flag for the register window |

## Verification
Select, space, offset, strobes, write data, acknowledge and configuration read data are combinational. They are due in the cycle the access is presented, so the bench drives on the falling edge and samples them a nanosecond later, before the next rising edge. Flag updates take one rising edge. `rd_valid` and `rd_data` are due after the rising edge that follows the request, so the bench samples them just after that edge. It also checks one edge later that `rd_valid` has dropped once the request is gone.

// File: rtl/modspace_pkg.sv
// Shared types and helpers for the module space decoder.
// Assumes a 16-bit data path split into two byte lanes.
package modspace_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        WIN_REGSP = 2'd0,
        WIN_MEM16 = 2'd1,
        WIN_MEM8  = 2'd2,
        WIN_NONE  = 2'd3
    } win_e;

    typedef enum logic [2:0] {
        SP_IO    = 3'd0,
        SP_ID    = 3'd1,
        SP_INT   = 3'd2,
        SP_MEM16 = 3'd3,
        SP_MEM8  = 3'd4
    } space_e;

    // Exchange the two byte lanes of a halfword.
    function automatic logic [DATA_W-1:0] swap_lanes(input logic [DATA_W-1:0] d);
        return {d[BYTE_W-1:0], d[DATA_W-1:BYTE_W]};
    endfunction
endpackage

// File: rtl/modspace_cfg.sv
// Byte-addressed configuration file holding the byte-order flags.
// Flag i lives in bit 0 of byte FLAG_OFS[i]. Reads OR the flag into a
// constant byte. Every other byte reads zero. Assumes distinct offsets.
module modspace_cfg #(
    parameter int N_FLAGS = 3,
    parameter int CADDR_W = 7,
    parameter logic [N_FLAGS*CADDR_W-1:0] FLAG_OFS  = {7'h33, 7'h2F, 7'h2B},
    parameter logic [N_FLAGS*8-1:0]       FLAG_BASE = {8'h14, 8'h14, 8'hD4}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [CADDR_W-1:0] cfg_addr,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    output logic [N_FLAGS-1:0] flags
);
    logic [N_FLAGS-1:0] hit;

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        assign hit[i] = (cfg_addr == FLAG_OFS[i*CADDR_W +: CADDR_W]);

        // Load the flag from bit 0 of a write to its byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (cfg_wr && hit[i])
                flags[i] <= cfg_wdata[0];
        end

        assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_wr && hit[i]) |=> $stable(flags[i]));
        assert_flag_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr && hit[i]) |=> (flags[i] == $past(cfg_wdata[0])));
    end

    // Merge the constant byte and flag of whichever entry is addressed.
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < N_FLAGS; i++)
            if (hit[i])
                cfg_rdata = FLAG_BASE[i*8 +: 8] | {7'b0, flags[i]};
    end
endmodule

// File: rtl/modspace_addr_map.sv
// Combinational address split for the three windows, with the byte-access
// address flip applied in big-endian mode. Reports slot number, whether it
// is in range, space, offset, whether the access form is legal and whether
// data lanes must be exchanged.
module modspace_addr_map
    import modspace_pkg::*;
#(
    parameter int ADDR_W      = 25,
    parameter int N_SLOTS     = 4,
    parameter int W0_SLOT_LSB = 8,
    parameter int W1_SLOT_LSB = 23,
    parameter int W2_SLOT_LSB = 22,
    localparam int SLOT_W     = $clog2(N_SLOTS),
    localparam int OFF_W      = W1_SLOT_LSB
) (
    input  logic [1:0]        win,
    input  logic              half,
    input  logic [ADDR_W-1:0] addr,
    input  logic              be_w0,
    input  logic              be_w1,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              slot_ok,
    output logic [2:0]        space,
    output logic [OFF_W-1:0]  offset,
    output logic              legal,
    output logic              swap
);
    localparam int SP_LSB = W0_SLOT_LSB - 2;

    logic [ADDR_W-1:0] ea;
    logic [ADDR_W-1:0] slot_full;
    logic              be;

    // Apply the byte-order address flip, then split by window.
    always_comb begin
        unique case (win_e'(win))
            WIN_REGSP: be = be_w0;
            WIN_MEM16: be = be_w1;
            default:   be = 1'b0;
        endcase
        ea = addr;
        if (be && !half)
            ea[0] = ~addr[0];
        swap      = be && half;
        legal     = 1'b1;
        space     = SP_IO;
        offset    = '0;
        slot_full = '0;
        unique case (win_e'(win))
            WIN_REGSP: begin
                slot_full = ea >> W0_SLOT_LSB;
                unique case (ea[SP_LSB+1:SP_LSB])
                    2'd2: begin
                        space  = SP_ID;
                        offset = OFF_W'(ea[SP_LSB-1:0]);
                    end
                    2'd3: begin
                        space  = SP_INT;
                        offset = OFF_W'(ea[SP_LSB-1:0]);
                    end
                    default: begin
                        space  = SP_IO;
                        offset = OFF_W'(ea[SP_LSB:0]);
                    end
                endcase
            end
            WIN_MEM16: begin
                slot_full = ea >> W1_SLOT_LSB;
                space     = SP_MEM16;
                offset    = ea[W1_SLOT_LSB-1:0];
            end
            WIN_MEM8: begin
                slot_full = addr >> W2_SLOT_LSB;
                space     = SP_MEM8;
                offset    = OFF_W'(addr[W2_SLOT_LSB-1:0]);
                legal     = !half;
            end
            default: legal = 1'b0;
        endcase
        slot_ok  = (slot_full < ADDR_W'(N_SLOTS));
        slot_idx = slot_full[SLOT_W-1:0];
    end
endmodule

// File: rtl/modspace_rd_ret.sv
// Registers the read return: exchanges lanes when required, zero-extends
// byte reads, and forces zero when the read hit no slot. The valid strobe
// follows every read request by one cycle. Assumes mod_rdata is valid in
// the request cycle.
module modspace_rd_ret
    import modspace_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              hit,
    input  logic              half,
    input  logic              swap,
    input  logic [DATA_W-1:0] mod_rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    // Capture the adjusted return word and raise valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                if (!hit)
                    rd_data <= '0;
                else if (!half)
                    rd_data <= {{(DATA_W-BYTE_W){1'b0}}, mod_rdata[BYTE_W-1:0]};
                else if (swap)
                    rd_data <= swap_lanes(mod_rdata);
                else
                    rd_data <= mod_rdata;
            end
        end
    end

    assert_rd_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    assert_rd_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
    assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !hit) |=> (rd_data == '0));
endmodule

// File: rtl/modspace_decoder.sv
// Top of the module space decoder. Combines the configuration flags, the
// address split and the read return. It produces the slot select,
// strobes, write data and interrupt acknowledges in the request cycle.
// Assumes one access per cycle and module read data in the same cycle.
module modspace_decoder
    import modspace_pkg::*;
#(
    parameter int ADDR_W  = 25,
    parameter int N_SLOTS = 4,
    parameter int CADDR_W = 7,
    localparam int SLOT_W = $clog2(N_SLOTS),
    localparam int OFF_W  = 23,
    localparam int ACK_W  = N_SLOTS * 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [1:0]         acc_win,
    input  logic               acc_half,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [15:0]        acc_wdata,
    input  logic [N_SLOTS-1:0] slot_present,
    output logic [N_SLOTS-1:0] mod_sel,
    output logic [2:0]         mod_space,
    output logic [OFF_W-1:0]   mod_offset,
    output logic               mod_wr,
    output logic               mod_rd,
    output logic [15:0]        mod_wdata,
    input  logic [15:0]        mod_rdata,
    output logic [ACK_W-1:0]   int_ack,
    output logic               rd_valid,
    output logic [15:0]        rd_data,
    input  logic               cfg_wr,
    input  logic [CADDR_W-1:0] cfg_addr,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    output logic               regwin_be
);
    logic [2:0]        flags;
    logic [SLOT_W-1:0] slot_idx;
    logic              slot_ok;
    logic              legal;
    logic              swap;
    logic              hit;

    modspace_cfg #(
        .N_FLAGS(3),
        .CADDR_W(CADDR_W)
    ) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .flags    (flags)
    );

    assign regwin_be = flags[0];

    modspace_addr_map #(
        .ADDR_W (ADDR_W),
        .N_SLOTS(N_SLOTS)
    ) i_map (
        .win     (acc_win),
        .half    (acc_half),
        .addr    (acc_addr),
        .be_w0   (flags[1]),
        .be_w1   (flags[2]),
        .slot_idx(slot_idx),
        .slot_ok (slot_ok),
        .space   (mod_space),
        .offset  (mod_offset),
        .legal   (legal),
        .swap    (swap)
    );

    // A slot is hit only for a legal, in-range access to an installed module.
    always_comb begin
        hit     = acc_valid && legal && slot_ok && slot_present[slot_idx];
        mod_sel = hit ? (N_SLOTS'(1) << slot_idx) : '0;
        mod_wr  = hit && acc_write;
        mod_rd  = hit && !acc_write;
    end

    // Exchange write lanes for big-endian halfword accesses.
    assign mod_wdata = swap ? swap_lanes(acc_wdata) : acc_wdata;

    // Pulse the acknowledge for a read at INT offset 0 (line 0) or 2 (line 1).
    always_comb begin
        int_ack = '0;
        if (mod_rd && space_e'(mod_space) == SP_INT &&
            mod_offset[OFF_W-1:2] == '0 && !mod_offset[0])
            int_ack[{slot_idx, mod_offset[1]}] = 1'b1;
    end

    modspace_rd_ret i_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (acc_valid && !acc_write),
        .hit      (hit),
        .half     (acc_half),
        .swap     (swap),
        .mod_rdata(mod_rdata),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assert_sel_present_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_sel & ~slot_present) == '0);
    assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mod_sel));
    assert_ack_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack != '0) |-> (mod_rd && !acc_write && $countones(int_ack) == 1));
    assert_mem8_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (space_e'(mod_space) == SP_MEM8 && mod_sel != '0) |-> !acc_half);
endmodule

// File: tb/test_modspace_decoder.sv
module test_modspace_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_half = 1'b0;
    logic [1:0]  acc_win = 2'd0;
    logic [24:0] acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic [3:0]  slot_present = 4'hF;
    logic [3:0]  mod_sel;
    logic [2:0]  mod_space;
    logic [22:0] mod_offset;
    logic        mod_wr, mod_rd;
    logic [15:0] mod_wdata;
    logic [15:0] mod_rdata = 16'hA1B2;
    logic [7:0]  int_ack;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        cfg_wr = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        regwin_be;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    modspace_decoder i_modspace_decoder (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_win(acc_win), .acc_half(acc_half), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .slot_present(slot_present), .mod_sel(mod_sel),
        .mod_space(mod_space), .mod_offset(mod_offset), .mod_wr(mod_wr),
        .mod_rd(mod_rd), .mod_wdata(mod_wdata), .mod_rdata(mod_rdata),
        .int_ack(int_ack), .rd_valid(rd_valid), .rd_data(rd_data),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .regwin_be(regwin_be)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Present an access on a falling edge; combinational outputs settle 1 ns later.
    task automatic drive(input logic wr, input logic [1:0] win, input logic half,
                         input logic [24:0] addr, input logic [15:0] wd);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_win = win;
        acc_half = half; acc_addr = addr; acc_wdata = wd;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0;
        #1;
    endtask

    // Registered read return: sample just after the next rising edge.
    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
    endtask

    task automatic cfg_read(input string req, input logic [6:0] a, input logic [7:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic t_reset();
        check("R1 rd_valid", rd_valid, 0);
        check("R1 regwin_be", regwin_be, 0);
        cfg_read("R1 flag byte 0x2F clear", 7'h2F, 8'h14);
    endtask

    task automatic t_win0();
        drive(0, 2'd0, 0, 25'h295, 16'h0);
        check("R2 ID sel", mod_sel, 4'b0100);
        check("R2 ID space", mod_space, 1);
        check("R2 ID offset", mod_offset, 23'h15);
        drive(0, 2'd0, 0, 25'h1C5, 16'h0);
        check("R2 INT sel", mod_sel, 4'b0010);
        check("R2 INT space", mod_space, 2);
        check("R2 INT offset", mod_offset, 23'h05);
        drive(1, 2'd0, 0, 25'h37F, 16'h0);
        check("R2 IO sel", mod_sel, 4'b1000);
        check("R2 IO space", mod_space, 0);
        check("R2 IO offset 7 bits", mod_offset, 23'h7F);
        check("R2 IO write strobe", mod_wr, 1);
        idle();
    endtask

    task automatic t_win1();
        drive(1, 2'd1, 1, 25'h1812345, 16'hBEEF);
        check("R3 sel", mod_sel, 4'b1000);
        check("R3 space", mod_space, 3);
        check("R3 offset", mod_offset, 23'h012345);
        check("R6 little-endian wdata", mod_wdata, 16'hBEEF);
        drive(0, 2'd1, 1, 25'h10, 16'h0);
        after_edge();
        check("R6 little-endian rdata", rd_data, 16'hA1B2);
        idle();
    endtask

    task automatic t_win2();
        drive(0, 2'd2, 0, 25'h8ABCD | (25'd2 << 22), 16'h0);
        check("R4 sel", mod_sel, 4'b0100);
        check("R4 space", mod_space, 4);
        check("R4 offset", mod_offset, 23'h08ABCD);
        drive(0, 2'd2, 1, 25'h10, 16'h0);
        check("R4 halfword no sel", mod_sel, 0);
        check("R4 halfword no strobe", mod_rd, 0);
        after_edge();
        check("R4 halfword reads zero", rd_data, 0);
        drive(0, 2'd2, 0, 25'd5 << 22, 16'h0);
        check("R10 slot 5 no sel", mod_sel, 0);
        drive(1, 2'd0, 0, 25'h400, 16'h0);
        check("R10 window 0 slot 4 no write", {mod_sel, mod_wr}, 0);
        idle();
    endtask

    task automatic t_cfg();
        cfg_write(7'h2F, 8'h01);
        cfg_read("R7 read 0x2F set", 7'h2F, 8'h15);
        cfg_write(7'h33, 8'hFF);
        cfg_read("R7 read 0x33 set", 7'h33, 8'h15);
        cfg_write(7'h2B, 8'h01);
        check("R7 regwin_be set", regwin_be, 1);
        cfg_read("R7 read 0x2B set", 7'h2B, 8'hD5);
        cfg_read("R7 other byte zero", 7'h00, 8'h00);
        cfg_write(7'h2B, 8'hFE);
        check("R7 regwin_be cleared by bit 0", regwin_be, 0);
    endtask

    // Runs with window 0 and window 1 flags set by t_cfg.
    task automatic t_endian();
        drive(0, 2'd0, 0, 25'h294, 16'h0);
        check("R5 window 0 byte flip", mod_offset, 23'h15);
        drive(1, 2'd0, 1, 25'h294, 16'h1234);
        check("R5 halfword no flip", mod_offset, 23'h14);
        check("R6 window 0 wdata swap", mod_wdata, 16'h3412);
        drive(0, 2'd1, 0, 25'h10, 16'h0);
        check("R5 window 1 byte flip", mod_offset, 23'h11);
        drive(0, 2'd1, 1, 25'h10, 16'h0);
        after_edge();
        check("R6 window 1 rdata swap", rd_data, 16'hB2A1);
        drive(0, 2'd2, 0, 25'h10, 16'h0);
        check("R4 no flip in byte window", mod_offset, 23'h10);
        idle();
        cfg_write(7'h2F, 8'h00);
        cfg_write(7'h33, 8'h00);
        drive(0, 2'd0, 0, 25'h294, 16'h0);
        check("R5 flag cleared no flip", mod_offset, 23'h14);
        idle();
    endtask

    task automatic t_intack();
        drive(0, 2'd0, 0, 25'h1C0, 16'h0);
        check("R8 slot1 line0 ack", int_ack, 8'h04);
        drive(0, 2'd0, 0, 25'h1C2, 16'h0);
        check("R8 slot1 line1 ack", int_ack, 8'h08);
        drive(0, 2'd0, 0, 25'h3C1, 16'h0);
        check("R8 offset 1 no ack", int_ack, 8'h00);
        drive(1, 2'd0, 0, 25'h1C0, 16'h0);
        check("R8 write no ack", int_ack, 8'h00);
        idle();
    endtask

    task automatic t_absent();
        slot_present = 4'b1101;
        drive(0, 2'd0, 0, 25'h1C0, 16'h0);
        check("R9 absent no sel", mod_sel, 0);
        check("R9 absent no read strobe", mod_rd, 0);
        check("R9 absent no ack", int_ack, 0);
        after_edge();
        check("R9 absent reads zero", rd_data, 0);
        drive(1, 2'd1, 1, 25'd1 << 23, 16'h5555);
        check("R9 absent no write strobe", mod_wr, 0);
        idle();
        slot_present = 4'hF;
    endtask

    task automatic t_rdtiming();
        idle();
        drive(0, 2'd1, 0, 25'h20, 16'h0);
        check("R11 no valid before edge", rd_valid, 0);
        after_edge();
        check("R11 valid after edge", rd_valid, 1);
        check("R11 byte read zero-extended", rd_data, 16'h00B2);
        idle();
        after_edge();
        check("R11 valid drops", rd_valid, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_win0();
        t_win1();
        t_win2();
        t_cfg();
        t_endian();
        t_intack();
        t_absent();
        t_rdtiming();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule